// File: doc/BRIEF.md
# Register-Programmed Single-Channel Copy Engine

The block moves a block of bytes from a source address to a destination address over one request/acknowledge memory port. Software sets it up through a small register bank. It writes a source address, a destination address, one configuration word for each side, a byte count and a direction flag, then writes a start command. Each side has its own access width (8, 16 or 32 bits) and address mode (incrementing or constant). The engine therefore converts widths on the way: it packs narrow source beats into wide destination beats, or splits wide beats into narrow ones. The byte stream is kept in little-endian order.

The direction flag tells the memory port which side of each access is the flash data-buffer window. Completion and failure are latched in a status register and cleared by separate command bits. A second register set holds the interrupt state. Its status bits are set by the done and error events and cleared by writing ones. A mask hides bits from the pending view and from the interrupt line.

Top module: `dma_copy_engine`

## Requirements
- R1: After reset every readable register (0x400 source address, 0x404 source config, 0x408 destination address, 0x40C destination config, 0x414 byte count, 0x41C status, 0x420 direction, 0x1024 mask, 0x1044 pending, 0x1064 interrupt status) reads 0, `irq` is low and `mem_req` is low.
- R2: Address, config, count and direction registers read back what was written. A config word keeps only burst code [18:16], address mode bit 8 and width code [1:0]. The direction register keeps bit 0. Unmapped offsets and the command register 0x418 read 0.
- R3: Writing bit 0 of 0x418 while idle starts a transfer. Status bit 17 (busy) is set while it runs. At the end, bit 18 (done) is set and stays set until a command write with bit 18. Status bit 16 (error) stays set until a command write with bit 16.
- R4: Width codes are 0 = 8-bit, 1 = 16-bit and 2 = 32-bit, and `mem_size` carries the code of the current access. Read data arrives right-justified in `mem_rdata`, and bytes above the access width are ignored. Write data is right-justified in `mem_wdata`. Source beats are packed little-endian into the destination stream, so stream byte i comes from source byte i and goes to destination byte i.
- R5: Config bit 8 = 0 advances that side's address by its access width after each beat. Bit 8 = 1 holds the address constant.
- R6: A start with a count of zero, a count that is not a multiple of the wider access width, a width code of 3, or a burst code outside {0, 2, 3, 4} sets error and makes no memory access.
- R7: A start written while busy is ignored. Registers written while busy read back their new values but do not change the running transfer.
- R8: When `mem_err` is raised instead of `mem_ack`, the transfer stops: `mem_req` drops on the next cycle, busy clears, done stays clear, and error is set in status bit 16 and in interrupt status bit 16.
- R9: Interrupt status bit 24 is set by done and bit 16 by error. Mask register 0x1024 bits 24 and 16 (1 = suppress) hide those bits. Pending 0x1044 reads status AND NOT mask, and `irq` is high when pending is nonzero.
- R10: Writing a 1 to bit 24 or 16 of 0x1004 clears that interrupt status bit. Zeros have no effect.
- R11: `mem_flash` marks accesses to the flash side. With direction 0, source reads have `mem_flash` = 1 and destination writes have 0. With direction 1 this is reversed.
- R12: Once raised, `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until `mem_ack` or `mem_err` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW (13) | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W (32) | Byte address of the access |
| mem_size | output | 2 | Width code of the access |
| mem_flash | output | 1 | Access targets the flash window |
| mem_wdata | output | 32 | Right-justified write data |
| mem_rdata | input | 32 | Right-justified read data |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access failed; ends the transfer |
| irq | output | 1 | Interrupt request |

## Verification
The cases hardest to reach from the ports are a memory error on a chosen beat in the middle of a packed transfer, and a new start plus reprogramming that arrive while a transfer is still moving data. The memory responder counts responses and answers a selected response number with an error instead of an acknowledge. Another test rewrites the destination and count and writes start again a few cycles into a long byte-wide copy. In both cases the bench checks the memory image and the number of accesses against its own byte-stream model. Random transfers with random widths, modes, directions and response latencies cover the packing paths.

// File: rtl/dma_copy_pkg.sv
package dma_copy_pkg;
  localparam int DATA_W = 32;

  localparam logic [15:0] OFS_SRC_ADDR = 16'h0400;
  localparam logic [15:0] OFS_SRC_CFG  = 16'h0404;
  localparam logic [15:0] OFS_DST_ADDR = 16'h0408;
  localparam logic [15:0] OFS_DST_CFG  = 16'h040C;
  localparam logic [15:0] OFS_SIZE     = 16'h0414;
  localparam logic [15:0] OFS_CMD      = 16'h0418;
  localparam logic [15:0] OFS_STATUS   = 16'h041C;
  localparam logic [15:0] OFS_DIR      = 16'h0420;
  localparam logic [15:0] OFS_INT_CLR  = 16'h1004;
  localparam logic [15:0] OFS_INT_MASK = 16'h1024;
  localparam logic [15:0] OFS_INT_PEND = 16'h1044;
  localparam logic [15:0] OFS_INT_STAT = 16'h1064;

  localparam int BIT_START    = 0;
  localparam int BIT_ERR      = 16;
  localparam int BIT_BUSY     = 17;
  localparam int BIT_DONE     = 18;
  localparam int BIT_INT_ERR  = 16;
  localparam int BIT_INT_DONE = 24;

  typedef struct packed {
    logic [2:0] burst;
    logic       cmode;
    logic [1:0] width;
  } side_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} seq_state_t;

  function automatic logic [2:0] width_bytes(input logic [1:0] code);
    case (code)
      2'd0:    width_bytes = 3'd1;
      2'd1:    width_bytes = 3'd2;
      2'd2:    width_bytes = 3'd4;
      default: width_bytes = 3'd0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] lane_mask(input logic [2:0] nbytes);
    case (nbytes)
      3'd1:    lane_mask = 32'h0000_00FF;
      3'd2:    lane_mask = 32'h0000_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic burst_ok(input logic [2:0] b);
    burst_ok = (b == 3'd0) || (b == 3'd2) || (b == 3'd3) || (b == 3'd4);
  endfunction
endpackage

// File: rtl/dma_copy_regs.sv
module dma_copy_regs
  import dma_copy_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24,
  parameter int REG_AW = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              busy,
  input  logic              done_evt,
  input  logic              err_evt,
  output logic [ADDR_W-1:0] src_addr_q,
  output logic [ADDR_W-1:0] dst_addr_q,
  output side_cfg_t         src_cfg_q,
  output side_cfg_t         dst_cfg_q,
  output logic [CNT_W-1:0]  size_q,
  output logic              dir_q,
  output logic              start_cmd,
  output logic              done_q,
  output logic              irq
);
  logic we_src_addr, we_src_cfg, we_dst_addr, we_dst_cfg;
  logic we_size, we_cmd, we_dir, we_iclr, we_mask;
  logic err_q, int_done_q, int_err_q, mask_done_q, mask_err_q;
  logic [31:0] int_stat, int_pend;

  assign we_src_addr = reg_we && (reg_addr == REG_AW'(OFS_SRC_ADDR));
  assign we_src_cfg  = reg_we && (reg_addr == REG_AW'(OFS_SRC_CFG));
  assign we_dst_addr = reg_we && (reg_addr == REG_AW'(OFS_DST_ADDR));
  assign we_dst_cfg  = reg_we && (reg_addr == REG_AW'(OFS_DST_CFG));
  assign we_size     = reg_we && (reg_addr == REG_AW'(OFS_SIZE));
  assign we_cmd      = reg_we && (reg_addr == REG_AW'(OFS_CMD));
  assign we_dir      = reg_we && (reg_addr == REG_AW'(OFS_DIR));
  assign we_iclr     = reg_we && (reg_addr == REG_AW'(OFS_INT_CLR));
  assign we_mask     = reg_we && (reg_addr == REG_AW'(OFS_INT_MASK));

  assign start_cmd = we_cmd && reg_wdata[BIT_START];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_addr_q  <= '0;
      dst_addr_q  <= '0;
      src_cfg_q   <= '0;
      dst_cfg_q   <= '0;
      size_q      <= '0;
      dir_q       <= 1'b0;
      mask_done_q <= 1'b0;
      mask_err_q  <= 1'b0;
    end else begin
      if (we_src_addr) src_addr_q <= reg_wdata[ADDR_W-1:0];
      if (we_dst_addr) dst_addr_q <= reg_wdata[ADDR_W-1:0];
      if (we_src_cfg)  src_cfg_q  <= {reg_wdata[18:16], reg_wdata[8], reg_wdata[1:0]};
      if (we_dst_cfg)  dst_cfg_q  <= {reg_wdata[18:16], reg_wdata[8], reg_wdata[1:0]};
      if (we_size)     size_q     <= reg_wdata[CNT_W-1:0];
      if (we_dir)      dir_q      <= reg_wdata[0];
      if (we_mask) begin
        mask_done_q <= reg_wdata[BIT_INT_DONE];
        mask_err_q  <= reg_wdata[BIT_INT_ERR];
      end
    end
  end

  // Latched events: a set in the same cycle as a clear wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      int_done_q <= 1'b0;
      int_err_q  <= 1'b0;
    end else begin
      if (done_evt) done_q <= 1'b1;
      else if (we_cmd && reg_wdata[BIT_DONE]) done_q <= 1'b0;
      if (err_evt) err_q <= 1'b1;
      else if (we_cmd && reg_wdata[BIT_ERR]) err_q <= 1'b0;
      if (done_evt) int_done_q <= 1'b1;
      else if (we_iclr && reg_wdata[BIT_INT_DONE]) int_done_q <= 1'b0;
      if (err_evt) int_err_q <= 1'b1;
      else if (we_iclr && reg_wdata[BIT_INT_ERR]) int_err_q <= 1'b0;
    end
  end

  always_comb begin
    int_stat = '0;
    int_stat[BIT_INT_DONE] = int_done_q;
    int_stat[BIT_INT_ERR]  = int_err_q;
    int_pend = '0;
    int_pend[BIT_INT_DONE] = int_done_q && !mask_done_q;
    int_pend[BIT_INT_ERR]  = int_err_q && !mask_err_q;
  end

  assign irq = |int_pend;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_AW'(OFS_SRC_ADDR): reg_rdata[ADDR_W-1:0] = src_addr_q;
      REG_AW'(OFS_DST_ADDR): reg_rdata[ADDR_W-1:0] = dst_addr_q;
      REG_AW'(OFS_SRC_CFG): begin
        reg_rdata[18:16] = src_cfg_q.burst;
        reg_rdata[8]     = src_cfg_q.cmode;
        reg_rdata[1:0]   = src_cfg_q.width;
      end
      REG_AW'(OFS_DST_CFG): begin
        reg_rdata[18:16] = dst_cfg_q.burst;
        reg_rdata[8]     = dst_cfg_q.cmode;
        reg_rdata[1:0]   = dst_cfg_q.width;
      end
      REG_AW'(OFS_SIZE):   reg_rdata[CNT_W-1:0] = size_q;
      REG_AW'(OFS_DIR):    reg_rdata[0] = dir_q;
      REG_AW'(OFS_STATUS): begin
        reg_rdata[BIT_ERR]  = err_q;
        reg_rdata[BIT_BUSY] = busy;
        reg_rdata[BIT_DONE] = done_q;
      end
      REG_AW'(OFS_INT_MASK): begin
        reg_rdata[BIT_INT_DONE] = mask_done_q;
        reg_rdata[BIT_INT_ERR]  = mask_err_q;
      end
      REG_AW'(OFS_INT_PEND): reg_rdata = int_pend;
      REG_AW'(OFS_INT_STAT): reg_rdata = int_stat;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_copy_seq.sv
module dma_copy_seq
  import dma_copy_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  side_cfg_t         src_cfg_i,
  input  side_cfg_t         dst_cfg_i,
  input  logic [CNT_W-1:0]  size_i,
  input  logic              dir_i,
  output logic              busy,
  output logic              done_evt,
  output logic              err_evt,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic              mem_flash,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err
);
  seq_state_t        state_q, state_d;
  logic [ADDR_W-1:0] sa_q, sa_d, da_q, da_d;
  logic [1:0]        sw_q, sw_d, dw_q, dw_d;
  logic              sc_q, sc_d, dc_q, dc_d, dir_q, dir_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [2:0]        fill_q, fill_d;
  logic [DATA_W-1:0] buf_q, buf_d;

  logic [2:0] sb_new, db_new, wide_new, sbq, dbq;
  logic       cfg_ok;

  assign sbq = width_bytes(sw_q);
  assign dbq = width_bytes(dw_q);

  always_comb begin
    sb_new   = width_bytes(src_cfg_i.width);
    db_new   = width_bytes(dst_cfg_i.width);
    wide_new = (sb_new > db_new) ? sb_new : db_new;
    cfg_ok   = (sb_new != 3'd0) && (db_new != 3'd0) &&
               burst_ok(src_cfg_i.burst) && burst_ok(dst_cfg_i.burst) &&
               (size_i != '0) &&
               ((size_i & CNT_W'(wide_new - 3'd1)) == '0);
  end

  always_comb begin
    state_d  = state_q;
    sa_d     = sa_q;
    da_d     = da_q;
    sw_d     = sw_q;
    dw_d     = dw_q;
    sc_d     = sc_q;
    dc_d     = dc_q;
    dir_d    = dir_q;
    rem_d    = rem_q;
    fill_d   = fill_q;
    buf_d    = buf_q;
    done_evt = 1'b0;
    err_evt  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (cfg_ok) begin
            sa_d    = src_addr_i;
            da_d    = dst_addr_i;
            sw_d    = src_cfg_i.width;
            dw_d    = dst_cfg_i.width;
            sc_d    = src_cfg_i.cmode;
            dc_d    = dst_cfg_i.cmode;
            dir_d   = dir_i;
            rem_d   = size_i;
            fill_d  = '0;
            buf_d   = '0;
            state_d = ST_RD;
          end else begin
            err_evt = 1'b1;
          end
        end
      end
      ST_RD: begin
        if (mem_err) begin
          err_evt = 1'b1;
          state_d = ST_IDLE;
        end else if (mem_ack) begin
          buf_d  = buf_q | ((mem_rdata & lane_mask(sbq)) << {fill_q, 3'b000});
          fill_d = fill_q + sbq;
          if (!sc_q) sa_d = sa_q + ADDR_W'(sbq);
          state_d = ((fill_q + sbq) >= dbq) ? ST_WR : ST_RD;
        end
      end
      ST_WR: begin
        if (mem_err) begin
          err_evt = 1'b1;
          state_d = ST_IDLE;
        end else if (mem_ack) begin
          buf_d  = buf_q >> {dbq, 3'b000};
          fill_d = fill_q - dbq;
          rem_d  = rem_q - CNT_W'(dbq);
          if (!dc_q) da_d = da_q + ADDR_W'(dbq);
          if (rem_q == CNT_W'(dbq)) begin
            done_evt = 1'b1;
            state_d  = ST_IDLE;
          end else begin
            state_d = ((fill_q - dbq) >= dbq) ? ST_WR : ST_RD;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sa_q    <= '0;
      da_q    <= '0;
      sw_q    <= '0;
      dw_q    <= '0;
      sc_q    <= 1'b0;
      dc_q    <= 1'b0;
      dir_q   <= 1'b0;
      rem_q   <= '0;
      fill_q  <= '0;
      buf_q   <= '0;
    end else begin
      state_q <= state_d;
      sa_q    <= sa_d;
      da_q    <= da_d;
      sw_q    <= sw_d;
      dw_q    <= dw_d;
      sc_q    <= sc_d;
      dc_q    <= dc_d;
      dir_q   <= dir_d;
      rem_q   <= rem_d;
      fill_q  <= fill_d;
      buf_q   <= buf_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign mem_req   = busy;
  assign mem_we    = (state_q == ST_WR);
  assign mem_addr  = mem_we ? da_q : sa_q;
  assign mem_size  = mem_we ? dw_q : sw_q;
  assign mem_flash = mem_we ? dir_q : !dir_q;
  assign mem_wdata = buf_q & lane_mask(dbq);
endmodule

// File: rtl/dma_copy_engine.sv
module dma_copy_engine
  import dma_copy_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24,
  parameter int REG_AW = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic              mem_flash,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic              irq
);
  logic              busy, done_evt, err_evt, start_cmd, dir_q, done_q;
  logic [ADDR_W-1:0] src_addr_q, dst_addr_q;
  side_cfg_t         src_cfg_q, dst_cfg_q;
  logic [CNT_W-1:0]  size_q;

  dma_copy_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_AW(REG_AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .done_evt  (done_evt),
    .err_evt   (err_evt),
    .src_addr_q(src_addr_q),
    .dst_addr_q(dst_addr_q),
    .src_cfg_q (src_cfg_q),
    .dst_cfg_q (dst_cfg_q),
    .size_q    (size_q),
    .dir_q     (dir_q),
    .start_cmd (start_cmd),
    .done_q    (done_q),
    .irq       (irq)
  );

  dma_copy_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_cmd),
    .src_addr_i(src_addr_q),
    .dst_addr_i(dst_addr_q),
    .src_cfg_i (src_cfg_q),
    .dst_cfg_i (dst_cfg_q),
    .size_i    (size_q),
    .dir_i     (dir_q),
    .busy      (busy),
    .done_evt  (done_evt),
    .err_evt   (err_evt),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_size  (mem_size),
    .mem_flash (mem_flash),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack),
    .mem_err   (mem_err)
  );
endmodule

// File: rtl/dma_copy_engine_chk.sv
module dma_copy_engine_chk
  import dma_copy_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24,
  parameter int REG_AW = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_ack,
  input logic              mem_err,
  input logic              irq,
  input logic              busy,
  input logic              start_cmd,
  input logic              done_evt,
  input logic              err_evt,
  input logic              done_q,
  input logic [CNT_W-1:0]  size_q
);
  assert_hold_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !mem_err) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_err) |=> !mem_req);

  assert_done_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(mem_req && mem_we && mem_ack && !mem_err));

  assert_zero_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cmd && !busy && (size_q == '0)) |=> !mem_req);

  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr == REG_AW'(OFS_INT_CLR)) && reg_wdata[BIT_INT_DONE] &&
     reg_wdata[BIT_INT_ERR] && !done_evt && !err_evt) |=> !irq);
endmodule

bind dma_copy_engine dma_copy_engine_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_AW(REG_AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .mem_ack  (mem_ack),
  .mem_err  (mem_err),
  .irq      (irq),
  .busy     (busy),
  .start_cmd(start_cmd),
  .done_evt (done_evt),
  .err_evt  (err_evt),
  .done_q   (done_q),
  .size_q   (size_q)
);

// File: tb/test_dma_copy_engine.sv
module test_dma_copy_engine;
  logic        clk, rst_n;
  logic        reg_we;
  logic [12:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_flash, mem_ack, mem_err, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;

  dma_copy_engine i_dma_copy_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_flash(mem_flash), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int acc_n = 0, err_beat = -1, flag_bad = 0, lat = 0;
  logic cur_dir = 1'b0;
  logic [7:0] mem  [0:1023];
  logic [7:0] snap [0:1023];
  logic [7:0] expm [0:1023];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL R3 watchdog actual=%0d expected<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // Memory responder: acts on falling edges, one response per request.
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0; lat = 0;
    end else if (mem_ack || mem_err) begin
      mem_ack = 1'b0; mem_err = 1'b0;
    end else if (mem_req) begin
      if (lat > 0) lat--;
      else begin
        if (mem_flash !== (mem_we ? cur_dir : !cur_dir)) flag_bad++;
        if (acc_n == err_beat) mem_err = 1'b1;
        else begin
          if (mem_we) begin
            for (int k = 0; k < (1 << mem_size); k++)
              mem[(mem_addr + k) & 1023] = mem_wdata[8*k +: 8];
          end else begin
            mem_rdata = $urandom;
            for (int k = 0; k < (1 << mem_size); k++)
              mem_rdata[8*k +: 8] = mem[(mem_addr + k) & 1023];
          end
          mem_ack = 1'b1;
        end
        acc_n++;
        lat = $urandom % 3;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a[12:0]; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a[12:0];
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] cfgw(input int bur, input int cm, input int w);
    return (32'(bur) << 16) | (32'(cm) << 8) | 32'(w);
  endfunction

  task automatic prog(input int src, input int dst, input logic [31:0] sc,
                      input logic [31:0] dc, input int cnt, input logic dir);
    wr(16'h0400, src); wr(16'h0404, sc);
    wr(16'h0408, dst); wr(16'h040C, dc);
    wr(16'h0414, cnt); wr(16'h0420, {31'd0, dir});
    cur_dir = dir;
  endtask

  task automatic fill_mem;
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 8'($urandom); snap[i] = mem[i]; expm[i] = mem[i];
    end
  endtask

  task automatic model(input int src, input int dst, input int sw, input int dw,
                       input int scm, input int dcm, input int cnt);
    int sb, db;
    sb = 1 << sw; db = 1 << dw;
    for (int i = 0; i < cnt; i++)
      expm[(dcm ? dst + (i % db) : dst + i) & 1023] =
        snap[(scm ? src + (i % sb) : src + i) & 1023];
  endtask

  task automatic wait_idle;
    logic [31:0] s;
    s = 32'h0002_0000;
    for (int i = 0; i < 20000 && s[17]; i++) rd(16'h041C, s);
  endtask

  task automatic mem_cmp(input string tag);
    int bad;
    bad = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== expm[i]) bad++;
    chk(tag, bad, 0);
  endtask

  task automatic clr_all;
    wr(16'h0418, 32'h0005_0000);
    wr(16'h1004, 32'h0101_0000);
  endtask

  // Full successful transfer with model, memory, access-count and status checks.
  task automatic xfer(input string tag, input int src, input int dst, input int sw,
                      input int dw, input int scm, input int dcm, input int sbur,
                      input int dbur, input int cnt, input logic dir);
    logic [31:0] s;
    clr_all();
    fill_mem();
    prog(src, dst, cfgw(sbur, scm, sw), cfgw(dbur, dcm, dw), cnt, dir);
    model(src, dst, sw, dw, scm, dcm, cnt);
    acc_n = 0; err_beat = -1;
    wr(16'h0418, 32'h1);
    wait_idle();
    mem_cmp({tag, " R4 data"});
    chk({tag, " R5 access count"}, acc_n, (cnt >> sw) + (cnt >> dw));
    rd(16'h041C, s);
    chk({tag, " R3 status done"}, s, 32'h0004_0000);
  endtask

  initial begin
    logic [31:0] d;
    int sw, dw, wide, cnt;
    void'($urandom(32'h5EED));
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    begin
      logic [15:0] ofs [10] = '{16'h0400, 16'h0404, 16'h0408, 16'h040C, 16'h0414,
                                16'h041C, 16'h0420, 16'h1024, 16'h1044, 16'h1064};
      for (int i = 0; i < 10; i++) begin
        rd(ofs[i], d);
        chk($sformatf("R1 reset reg %h", ofs[i]), d, 0);
      end
    end
    chk("R1 reset irq", {31'd0, irq}, 0);
    chk("R1 reset mem_req", {31'd0, mem_req}, 0);

    // R2: readback with field masking
    wr(16'h0404, 32'hFFFF_FFFF); rd(16'h0404, d); chk("R2 cfg mask", d, 32'h0007_0103);
    wr(16'h0420, 32'hFFFF_FFFF); rd(16'h0420, d); chk("R2 dir mask", d, 1);
    wr(16'h0408, 32'hDEAD_BEEF); rd(16'h0408, d); chk("R2 dst addr", d, 32'hDEAD_BEEF);
    rd(16'h0418, d); chk("R2 cmd reads zero", d, 0);

    // Directed transfers: read pattern, write pattern, byte packing, constant modes
    xfer("read16to32",  16, 520, 1, 2, 0, 0, 4, 4, 64, 1'b0);
    rd(16'h1064, d); chk("R9 int status done", d, 32'h0100_0000);
    chk("R9 irq on done", {31'd0, irq}, 1);
    chk("R11 flash flag", flag_bad, 0);
    repeat (20) @(negedge clk);
    rd(16'h041C, d); chk("R3 done stays latched", d, 32'h0004_0000);
    xfer("write32to16", 40, 600, 2, 1, 0, 0, 4, 4, 32, 1'b1);
    xfer("byte8to32",   3, 700, 0, 2, 0, 0, 0, 2, 16, 1'b0);
    xfer("split32to8",  8, 640, 2, 0, 0, 0, 3, 0, 12, 1'b1);
    xfer("srcconst",    100, 800, 1, 1, 1, 0, 0, 0, 8, 1'b0);
    xfer("dstconst",    120, 900, 0, 1, 0, 1, 2, 2, 10, 1'b0);
    chk("R11 flash flag directed", flag_bad, 0);

    // R9/R10: mask, pending, write-one-to-clear
    wr(16'h1024, 32'h0100_0000);
    rd(16'h1044, d); chk("R9 pending masked", d, 0);
    chk("R9 irq masked", {31'd0, irq}, 0);
    rd(16'h1064, d); chk("R9 status kept under mask", d, 32'h0100_0000);
    wr(16'h1024, 32'h0);
    rd(16'h1044, d); chk("R9 pending unmasked", d, 32'h0100_0000);
    wr(16'h1004, 32'h0001_0000);
    rd(16'h1064, d); chk("R10 zero bit no effect", d, 32'h0100_0000);
    wr(16'h1004, 32'h0100_0000);
    rd(16'h1064, d); chk("R10 w1c clears", d, 0);
    chk("R10 irq low", {31'd0, irq}, 0);
    wr(16'h0418, 32'h0004_0000);
    rd(16'h041C, d); chk("R3 done clear cmd", d, 0);

    // R6: rejected configurations
    begin
      int cases_c [4] = '{0, 6, 8, 8};
      int cases_w [4] = '{0, 2, 3, 0};
      int cases_b [4] = '{0, 0, 0, 1};
      for (int i = 0; i < 4; i++) begin
        clr_all();
        prog(0, 512, cfgw(cases_b[i], 0, cases_w[i]), cfgw(0, 0, 0), cases_c[i], 1'b0);
        acc_n = 0;
        wr(16'h0418, 32'h1);
        repeat (5) @(negedge clk);
        rd(16'h041C, d); chk($sformatf("R6 reject case %0d status", i), d, 32'h0001_0000);
        chk($sformatf("R6 reject case %0d no access", i), acc_n, 0);
      end
    end
    rd(16'h1064, d); chk("R9 int status error", d, 32'h0001_0000);
    wr(16'h0418, 32'h0001_0000);
    rd(16'h041C, d); chk("R3 error clear cmd", d, 0);

    // R7: start and reprogramming while busy
    clr_all();
    fill_mem();
    prog(0, 512, cfgw(0, 0, 0), cfgw(0, 0, 0), 64, 1'b0);
    model(0, 512, 0, 0, 0, 0, 64);
    acc_n = 0; err_beat = -1;
    wr(16'h0418, 32'h1);
    repeat (10) @(negedge clk);
    wr(16'h0408, 32'd960); wr(16'h0414, 32'd4);
    wr(16'h0418, 32'h1);
    wait_idle();
    mem_cmp("R7 busy start ignored data");
    chk("R7 busy start access count", acc_n, 128);
    rd(16'h0408, d); chk("R7 new value reads back", d, 960);

    // R8: error response mid-transfer (fourth response: r,r,w,r)
    clr_all();
    fill_mem();
    prog(16, 520, cfgw(4, 0, 1), cfgw(4, 0, 2), 16, 1'b0);
    acc_n = 0; err_beat = 3;
    wr(16'h0418, 32'h1);
    wait_idle();
    repeat (20) @(negedge clk);
    chk("R8 access count stops", acc_n, 4);
    rd(16'h041C, d); chk("R8 status error only", d, 32'h0001_0000);
    rd(16'h1064, d); chk("R8 int status error", d, 32'h0001_0000);
    chk("R8 irq on error", {31'd0, irq}, 1);
    err_beat = -1;

    // Random transfers
    for (int t = 0; t < 24; t++) begin
      int bur [4] = '{0, 2, 3, 4};
      sw = $urandom % 3; dw = $urandom % 3;
      wide = (sw > dw) ? sw : dw;
      cnt = (1 << wide) * (1 + $urandom % 16);
      xfer($sformatf("rand%0d", t), $urandom % 200, 512 + $urandom % 200, sw, dw,
           ($urandom % 4) == 0, ($urandom % 4) == 0, bur[$urandom % 4],
           bur[$urandom % 4], cnt, 1'($urandom));
    end
    chk("R11 flash flag random", flag_bad, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule